// File: doc/BRIEF.md
# Integer Twin Butterfly Unit

A pipelined fixed-point butterfly for FFT and DCT inner loops. Each operation takes two signed data operands `a` and `b`, one signed coefficient and a shift amount. It forms a single product `b * coef` at double width. The product is scaled by an arithmetic right shift, with optional round-half-up. The scaled value `p` is then used twice. The block returns `a + p` and `b - p`, which go back into the slots that held `a` and `b`. The operation therefore has two outputs and needs no third destination.

The unit has two stages: multiply, then scale and add/subtract. It accepts one operation per cycle, and results appear two cycles after acceptance. Sums wrap modulo 2^DATA_W and are never saturated.

Top module: `int_twin_bfly`

## Requirements
- R1: Each operation uses exactly one product. For every result, `sum_o - a == b - diff_o` modulo 2^DATA_W.
- R2: `sum_o` equals `a_i + p`, where `p` is the low DATA_W bits of the scaled product `b_i * coef_i`. Operands and the product are signed two's complement.
- R3: `diff_o` equals `b_i - p`, with the same `p` as R2.
- R4: The full 2*DATA_W-bit product is shifted arithmetically right by `shift_i` (0 to DATA_W-1). With `shift_i` = 0, `p` is the low half of the product.
- R5: When `rnd_i` = 1 and `shift_i` > 0, 2^(shift_i-1) is added to the product before the shift (round half up). When `rnd_i` = 0 or `shift_i` = 0, no bias is added, so the shift floors.
- R6: Both results wrap modulo 2^DATA_W, including when operands are the most negative value.
- R7: `in_ready_o` is 1 whenever reset is released. An operation accepted at a rising edge yields `out_valid_o` = 1 after exactly two more rising edges. Back-to-back operations come out back to back, in order.
- R8: During reset, `out_valid_o`, `sum_o` and `diff_o` are 0. In a cycle with no completing operation, `sum_o` and `diff_o` hold their previous values whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present on the inputs |
| in_ready_o | output | 1 | Unit can accept an operation |
| a_i | input | DATA_W | Data operand receiving the sum |
| b_i | input | DATA_W | Data operand, multiplied, and receiving the difference |
| coef_i | input | DATA_W | Coefficient |
| shift_i | input | SHIFT_W | Right shift applied to the product |
| rnd_i | input | 1 | Enable round-half-up before the shift |
| out_valid_o | output | 1 | Results valid |
| sum_o | output | DATA_W | a + p |
| diff_o | output | DATA_W | b - p |

## Verification
The hardest situation to reach is a dense stream of operations with different shift and rounding settings in consecutive slots. A stage that mixes one operation's shift amount with a neighbour's product only shows up under such a stream. The bench therefore issues a long back-to-back random run, matching results in order against a queue of independently computed expectations. Directed cases cover rounding on negative half-way products and most-negative operands whose product or difference wraps.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int unsigned DATA_W_DEF  = 32;
  localparam int unsigned SHIFT_W_DEF = $clog2(DATA_W_DEF);
endpackage

// File: rtl/bfly_mul_stage.sv
module bfly_mul_stage #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 5,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic signed [DATA_W-1:0]  a_i,
  input  logic signed [DATA_W-1:0]  b_i,
  input  logic signed [DATA_W-1:0]  coef_i,
  input  logic [SHIFT_W-1:0]        shift_i,
  input  logic                      rnd_i,
  output logic                      valid_o,
  output logic signed [PROD_W-1:0]  prod_o,
  output logic signed [DATA_W-1:0]  a_o,
  output logic signed [DATA_W-1:0]  b_o,
  output logic [SHIFT_W-1:0]        shift_o,
  output logic                      rnd_o
);
  logic signed [PROD_W-1:0] prod_d;
  assign prod_d = PROD_W'(b_i) * PROD_W'(coef_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
      a_o     <= '0;
      b_o     <= '0;
      shift_o <= '0;
      rnd_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        prod_o  <= prod_d;
        a_o     <= a_i;
        b_o     <= b_i;
        shift_o <= shift_i;
        rnd_o   <= rnd_i;
      end
    end
  end
endmodule

// File: rtl/bfly_scale.sv
module bfly_scale #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 5,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic signed [PROD_W-1:0] prod_i,
  input  logic [SHIFT_W-1:0]       shift_i,
  input  logic                     rnd_i,
  output logic signed [DATA_W-1:0] p_o
);
  logic signed [PROD_W-1:0] bias;
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] shifted;

  // half-LSB bias of the retained part; no bias when nothing is shifted out
  always_comb begin
    bias = '0;
    if (rnd_i && (shift_i != '0))
      bias = PROD_W'(1) << (shift_i - SHIFT_W'(1));
  end

  assign biased  = prod_i + bias;
  assign shifted = biased >>> shift_i;
  assign p_o     = shifted[DATA_W-1:0];
endmodule

// File: rtl/bfly_addsub_stage.sv
module bfly_addsub_stage #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [DATA_W-1:0] b_i,
  input  logic signed [DATA_W-1:0] p_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] sum_o,
  output logic signed [DATA_W-1:0] diff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      diff_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sum_o  <= a_i + p_i;
        diff_o <= b_i - p_i;
      end
    end
  end
endmodule

// File: rtl/int_twin_bfly.sv
module int_twin_bfly #(
  parameter int unsigned DATA_W  = bfly_pkg::DATA_W_DEF,
  parameter int unsigned SHIFT_W = $clog2(DATA_W),
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [DATA_W-1:0]  a_i,
  input  logic [DATA_W-1:0]  b_i,
  input  logic [DATA_W-1:0]  coef_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic               rnd_i,
  output logic               out_valid_o,
  output logic [DATA_W-1:0]  sum_o,
  output logic [DATA_W-1:0]  diff_o
);
  logic                     s1_valid;
  logic signed [PROD_W-1:0] s1_prod;
  logic signed [DATA_W-1:0] s1_a, s1_b, s1_p;
  logic [SHIFT_W-1:0]       s1_shift;
  logic                     s1_rnd;
  logic signed [DATA_W-1:0] sum_s, diff_s;

  // fully pipelined, no output backpressure
  assign in_ready_o = 1'b1;

  bfly_mul_stage #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) i_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i & in_ready_o),
    .a_i     (a_i),
    .b_i     (b_i),
    .coef_i  (coef_i),
    .shift_i (shift_i),
    .rnd_i   (rnd_i),
    .valid_o (s1_valid),
    .prod_o  (s1_prod),
    .a_o     (s1_a),
    .b_o     (s1_b),
    .shift_o (s1_shift),
    .rnd_o   (s1_rnd)
  );

  bfly_scale #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) i_scale (
    .prod_i  (s1_prod),
    .shift_i (s1_shift),
    .rnd_i   (s1_rnd),
    .p_o     (s1_p)
  );

  bfly_addsub_stage #(.DATA_W(DATA_W)) i_addsub (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .a_i     (s1_a),
    .b_i     (s1_b),
    .p_i     (s1_p),
    .valid_o (out_valid_o),
    .sum_o   (sum_s),
    .diff_o  (diff_s)
  );

  assign sum_o  = sum_s;
  assign diff_o = diff_s;
endmodule

// File: rtl/int_twin_bfly_chk.sv
module int_twin_bfly_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic [DATA_W-1:0]  coef_i,
  input logic [SHIFT_W-1:0] shift_i,
  input logic               out_valid_o,
  input logic [DATA_W-1:0]  sum_o,
  input logic [DATA_W-1:0]  diff_o
);
  logic [1:0]        age;
  logic [DATA_W-1:0] low_prod;

  assign low_prod = b_i * coef_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2) |-> (out_valid_o == $past(in_valid_i && in_ready_o, 2)));

  a_r1_one_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && out_valid_o) |->
      ((sum_o - $past(a_i, 2)) == ($past(b_i, 2) - diff_o)));

  a_r4_no_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd2 && out_valid_o && $past(shift_i, 2) == '0) |->
      (sum_o == $past(a_i, 2) + $past(low_prod, 2)));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age >= 2'd1 && !out_valid_o) |-> ($stable(sum_o) && $stable(diff_o)));
endmodule

bind int_twin_bfly int_twin_bfly_chk #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .a_i         (a_i),
  .b_i         (b_i),
  .coef_i      (coef_i),
  .shift_i     (shift_i),
  .out_valid_o (out_valid_o),
  .sum_o       (sum_o),
  .diff_o      (diff_o)
);

// File: tb/test_int_twin_bfly.sv
module test_int_twin_bfly;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int SW = 5;

  typedef struct {
    logic [DW-1:0] sum;
    logic [DW-1:0] diff;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    int            cyc;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] a = '0, b = '0, coef = '0;
  logic [SW-1:0] shift = '0;
  logic          rnd = 1'b0;
  logic          out_valid;
  logic [DW-1:0] sum, diff;

  int   n_tests = 0;
  int   n_fail  = 0;
  int   cyc     = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int_twin_bfly i_int_twin_bfly (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a), .b_i(b), .coef_i(coef), .shift_i(shift), .rnd_i(rnd),
    .out_valid_o(out_valid), .sum_o(sum), .diff_o(diff)
  );

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_p(logic [DW-1:0] bv, logic [DW-1:0] cv,
                                            logic [SW-1:0] sh, logic r);
    longint prod;
    prod = longint'($signed(bv)) * longint'($signed(cv));
    if (r && sh != 0) prod = prod + (64'sd1 <<< (sh - 1));
    prod = prod >>> sh;
    return prod[DW-1:0];
  endfunction

  // result scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk("R7 unexpected out_valid", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " R2 sum"}, sum, e.sum);
        chk({e.tag, " R3 diff"}, diff, e.diff);
        chk({e.tag, " R1 shared product"}, sum - e.a, e.b - diff);
        chk({e.tag, " R7 latency"}, DW'(cyc), DW'(e.cyc + 2));
      end
    end
  end

  task automatic issue(logic [DW-1:0] av, logic [DW-1:0] bv, logic [DW-1:0] cv,
                       logic [SW-1:0] sh, logic r, string tag);
    exp_t e;
    logic [DW-1:0] p;
    @(negedge clk);
    in_valid = 1'b1; a = av; b = bv; coef = cv; shift = sh; rnd = r;
    p = model_p(bv, cv, sh, r);
    e.sum = av + p; e.diff = bv - p; e.a = av; e.b = bv;
    e.cyc = cyc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R8 reset out_valid", DW'(out_valid), '0);
    chk("R8 reset sum", sum, '0);
    chk("R8 reset diff", diff, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ready after reset", DW'(in_ready), 32'd1);
  endtask

  task automatic t_plain();
    issue(32'd10, 32'd3, 32'd4, 5'd0, 1'b0, "R4 plain");
    issue(32'd0, -32'sd7, 32'd5, 5'd0, 1'b1, "R4 neg no shift");
    issue(32'd100, 32'd1000, 32'd1000, 5'd4, 1'b0, "R4 shift4");
    idle(3);
  endtask

  task automatic t_round();
    issue(32'd0, 32'd3, 32'd1, 5'd1, 1'b1, "R5 pos half up");
    issue(32'd0, 32'd3, 32'd1, 5'd1, 1'b0, "R5 pos floor");
    issue(32'd0, -32'sd3, 32'd1, 5'd1, 1'b1, "R5 neg half up");
    issue(32'd0, -32'sd3, 32'd1, 5'd1, 1'b0, "R5 neg floor");
    issue(32'd5, 32'd7, 32'd9, 5'd31, 1'b1, "R5 max shift");
    idle(3);
  endtask

  task automatic t_corner();
    issue(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 5'd0, 1'b0, "R6 minneg sh0");
    issue(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 5'd31, 1'b1, "R6 minneg sh31");
    issue(32'h7fff_ffff, 32'h8000_0000, 32'd1, 5'd0, 1'b0, "R6 wrap");
    issue(32'h8000_0000, 32'h7fff_ffff, 32'hffff_ffff, 5'd0, 1'b0, "R6 wrap neg");
    idle(3);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 300; i++)
      issue($urandom, $urandom, $urandom, SW'($urandom), 1'($urandom), "R7 stream");
    idle(4);
    chk("R7 stream drained", DW'(q.size()), '0);
  endtask

  task automatic t_hold();
    logic [DW-1:0] s0, d0;
    issue(32'd11, 32'd22, 32'd3, 5'd0, 1'b0, "R8 pre-hold");
    idle(3);
    s0 = sum; d0 = diff;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b0; a = $urandom; b = $urandom; coef = $urandom;
    end
    chk("R8 hold sum", sum, s0);
    chk("R8 hold diff", diff, d0);
    chk("R8 hold valid", DW'(out_valid), '0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_plain();
        t_round();
        t_corner();
        t_stream();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule